// File: doc/BRIEF.md
# Host command and reply queue port

This block is the device-side register window of a storage controller. A host talks to it over a plain 32-bit memory-mapped bus made of an address, a write strobe, a read strobe, write data and read data. When the host writes the request port, the block places a command address into an inbound queue. The device core drains that queue through a valid/pop interface. Going the other way, the device core pushes completion words into an outbound queue, and the host reads them back one at a time from the reply port.

Around the two queues sit a few registers: an interrupt mask with inverted polarity, an interrupt status word, a doorbell word, a scratchpad that reports firmware readiness, and two read-only location words whose values are set by parameters. The device raises a single interrupt line while replies are waiting and the host has not masked them. A single parameter selects one of two register variants. The variant decides which bit position masks the interrupt and which bit position reports a pending reply.

Top module: `cqp_host_port`

## Requirements
- R1: Each clock edge at which the write strobe is high with address 0x40 appends the write data to the request queue. The device sees the oldest entry on `req_data` while `req_valid` is high, and `req_pop` removes it, so entries leave in the order they were written.
- R2: A request-port write while the request queue holds DEPTH entries is discarded. It also sets bit 0 of the status word at 0x30, and that bit stays set until reset.
- R3: A read of 0x44 while the reply queue holds data returns the oldest completion word on `bus_rdata` after the first clock edge of the read strobe, and removes that word from the queue.
- R4: A read of 0x44 while the reply queue is empty returns 0xFFFFFFFF and leaves both queues, the registers and the interrupt line unchanged.
- R5: A read strobe held high for several cycles counts as one access and removes at most one reply word. `bus_rdata` is updated only on the first edge of each strobe.
- R6: The mask word at 0x34 can be written and read back. After reset it holds the disable value, which is 0x08 in variant A and 0x04 in variant B.
- R7: `irq` is high one cycle after the reply queue is non-empty and the variant's mask bit is clear (bit 3 in variant A, bit 2 in variant B). Otherwise it is low.
- R8: Status bit 3 in variant A, or bit 2 in variant B, reads 1 exactly when the reply queue is non-empty.
- R9: A read of 0xB0 returns 0xFFFF0000 while `fw_ready` is high, and 0 while it is low.
- R10: The doorbell word at 0x20 can be written and read back. 0xB4 and 0xB8 return the parameters CFG_TBL_LOC and CFG_MEM_LOC. Unmapped addresses read 0.
- R11: A device push into a full reply queue is ignored. `rsp_full` is high exactly when the reply queue holds DEPTH entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Host byte address |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_wdata | input | DATA_W | Host write data |
| bus_rdata | output | DATA_W | Host read data, registered |
| req_valid | output | 1 | Request queue holds an entry |
| req_data | output | DATA_W | Oldest request entry |
| req_pop | input | 1 | Device removes the oldest request entry |
| rsp_push | input | 1 | Device appends a completion word |
| rsp_data | input | DATA_W | Completion word to append |
| rsp_full | output | 1 | Reply queue is full |
| fw_ready | input | 1 | Device firmware is ready |
| irq | output | 1 | Reply interrupt, active high |

## Verification
The embedded assertions are evaluated on every cycle. They check that a full queue never accepts an entry, that an empty reply read produces the all-ones word without removing anything, that a held strobe never removes a second entry, and that the interrupt only rises after replies were waiting. Some behaviours can only be shown by the bench's scenarios, because they need known data to be compared:
- queue ordering,
- the dropped overflow word and the sticky overflow bit,
- the variant-specific reset values and bit positions in both variants,
- the scratchpad and location words,
- the interrupt following mask writes.

// File: rtl/cqp_pkg.sv
// Package: shared address map, constants and variant type for the
// host command/reply queue port. Assumes byte addresses of 8 bits.
package cqp_pkg;
    typedef enum logic [0:0] {VAR_A = 1'b0, VAR_B = 1'b1} cqp_variant_e;

    localparam logic [7:0] OFS_DOORBELL = 8'h20;
    localparam logic [7:0] OFS_STATUS   = 8'h30;
    localparam logic [7:0] OFS_MASK     = 8'h34;
    localparam logic [7:0] OFS_REQUEST  = 8'h40;
    localparam logic [7:0] OFS_REPLY    = 8'h44;
    localparam logic [7:0] OFS_SCRATCH  = 8'hB0;
    localparam logic [7:0] OFS_CFG_TBL  = 8'hB4;
    localparam logic [7:0] OFS_CFG_MEM  = 8'hB8;

    localparam logic [31:0] WORD_EMPTY    = 32'hFFFF_FFFF;
    localparam logic [31:0] WORD_FW_READY = 32'hFFFF_0000;

    // Bit position used for both the mask and the pending flag.
    function automatic int unsigned flag_bit(cqp_variant_e v);
        return (v == VAR_B) ? 2 : 3;
    endfunction
endpackage

// File: rtl/cqp_fifo.sv
// Module: cqp_fifo
// Synchronous first-in first-out queue with first-word-through head output.
// Assumes DEPTH is a power of two. A push while full is discarded, even
// when a pop happens in the same cycle. A pop while empty is ignored.
module cqp_fifo #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW:0]      wr_ptr;
    logic [AW:0]      rd_ptr;
    logic [AW:0]      count;
    logic             do_push;
    logic             do_pop;

    // Occupancy and flags derived from the pointer difference.
    always_comb begin
        count   = wr_ptr - rd_ptr;
        empty   = (count == '0);
        full    = (count == (AW+1)'(DEPTH));
        do_push = push && !full;
        do_pop  = pop && !empty;
        head    = mem[rd_ptr[AW-1:0]];
    end

    // Pointer update on accepted pushes and pops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
        end
    end

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr[AW-1:0]] <= push_data;
    end

    // R2 / R11: a full queue never grows.
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (count == $past(count)));

    // Occupancy never exceeds the depth.
    assert_count_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        count <= (AW+1)'(DEPTH));
endmodule

// File: rtl/cqp_regs.sv
// Module: cqp_regs
// Host register file: decodes reads, latches the read data, pops the
// reply queue once per read strobe, holds the mask, doorbell and sticky
// overflow flag, and drives the registered interrupt. Assumes the queues
// live outside and report empty and head.
module cqp_regs
    import cqp_pkg::*;
#(
    parameter int unsigned  DATA_W      = 32,
    parameter int unsigned  ADDR_W      = 8,
    parameter int unsigned  FLAG_BIT    = 3,
    parameter logic [31:0]  CFG_TBL_LOC = 32'h0000_2000,
    parameter logic [31:0]  CFG_MEM_LOC = 32'h0000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              fw_ready,
    input  logic              req_overflow,
    input  logic              rep_empty,
    input  logic [DATA_W-1:0] rep_head,
    output logic              rep_pop,
    output logic              irq
);
    localparam logic [DATA_W-1:0] MASK_OFF = DATA_W'(1) << FLAG_BIT;

    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] doorbell_q;
    logic              ovf_q;
    logic              rd_q;
    logic              rd_start;
    logic [DATA_W-1:0] rd_mux;

    // Read strobe edge detect and address decode of the read value.
    always_comb begin
        rd_start = bus_rd && !rd_q;
        rep_pop  = rd_start && (bus_addr == ADDR_W'(OFS_REPLY)) && !rep_empty;
        rd_mux   = '0;
        case (bus_addr)
            ADDR_W'(OFS_DOORBELL): rd_mux = doorbell_q;
            ADDR_W'(OFS_STATUS): begin
                rd_mux[FLAG_BIT] = !rep_empty;
                rd_mux[0]        = ovf_q;
            end
            ADDR_W'(OFS_MASK):    rd_mux = mask_q;
            ADDR_W'(OFS_REPLY):   rd_mux = rep_empty ? DATA_W'(WORD_EMPTY) : rep_head;
            ADDR_W'(OFS_SCRATCH): rd_mux = fw_ready ? DATA_W'(WORD_FW_READY) : '0;
            ADDR_W'(OFS_CFG_TBL): rd_mux = DATA_W'(CFG_TBL_LOC);
            ADDR_W'(OFS_CFG_MEM): rd_mux = DATA_W'(CFG_MEM_LOC);
            default:              rd_mux = '0;
        endcase
    end

    // Latch read data on the first edge of each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q      <= 1'b0;
            bus_rdata <= '0;
        end else begin
            rd_q <= bus_rd;
            if (rd_start) bus_rdata <= rd_mux;
        end
    end

    // Host-writable mask and doorbell words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q     <= MASK_OFF;
            doorbell_q <= '0;
        end else if (bus_wr) begin
            if (bus_addr == ADDR_W'(OFS_MASK))     mask_q     <= bus_wdata;
            if (bus_addr == ADDR_W'(OFS_DOORBELL)) doorbell_q <= bus_wdata;
        end
    end

    // Sticky request overflow flag and registered interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
            irq   <= 1'b0;
        end else begin
            if (req_overflow) ovf_q <= 1'b1;
            irq <= !rep_empty && !mask_q[FLAG_BIT];
        end
    end

    assert_empty_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_start && bus_addr == ADDR_W'(OFS_REPLY) && rep_empty)
            |-> (!rep_pop ##1 bus_rdata == DATA_W'(WORD_EMPTY)));

    assert_single_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && rd_q) |-> !rep_pop);

    assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(!rep_empty));

    assert_sticky_ovf_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ovf_q) |-> ovf_q);
endmodule

// File: rtl/cqp_host_port.sv
// Module: cqp_host_port (top)
// Host-facing command and reply queue port for a storage controller.
// The request queue is filled by host writes and drained by the device.
// The reply queue is filled by the device and drained by host reads.
// Assumes a single clock domain and a one-word bus with byte addresses.
module cqp_host_port
    import cqp_pkg::*;
#(
    parameter cqp_variant_e VARIANT     = VAR_A,
    parameter int unsigned  DATA_W      = 32,
    parameter int unsigned  ADDR_W      = 8,
    parameter int unsigned  REQ_DEPTH   = 8,
    parameter int unsigned  RSP_DEPTH   = 8,
    parameter logic [31:0]  CFG_TBL_LOC = 32'h0000_2000,
    parameter logic [31:0]  CFG_MEM_LOC = 32'h0000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              req_valid,
    output logic [DATA_W-1:0] req_data,
    input  logic              req_pop,
    input  logic              rsp_push,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              rsp_full,
    input  logic              fw_ready,
    output logic              irq
);
    localparam int unsigned FLAG_BIT = flag_bit(VARIANT);

    logic              req_push;
    logic              req_empty;
    logic              req_full;
    logic              rep_empty;
    logic              rep_pop;
    logic [DATA_W-1:0] rep_head;

    // Request-port write decode and device-side valid.
    always_comb begin
        req_push  = bus_wr && (bus_addr == ADDR_W'(OFS_REQUEST));
        req_valid = !req_empty;
    end

    cqp_fifo #(.WIDTH(DATA_W), .DEPTH(REQ_DEPTH)) u_req_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (req_push),
        .push_data (bus_wdata),
        .pop       (req_pop),
        .head      (req_data),
        .empty     (req_empty),
        .full      (req_full)
    );

    cqp_fifo #(.WIDTH(DATA_W), .DEPTH(RSP_DEPTH)) u_rsp_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rsp_push),
        .push_data (rsp_data),
        .pop       (rep_pop),
        .head      (rep_head),
        .empty     (rep_empty),
        .full      (rsp_full)
    );

    cqp_regs #(
        .DATA_W      (DATA_W),
        .ADDR_W      (ADDR_W),
        .FLAG_BIT    (FLAG_BIT),
        .CFG_TBL_LOC (CFG_TBL_LOC),
        .CFG_MEM_LOC (CFG_MEM_LOC)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_wr       (bus_wr),
        .bus_rd       (bus_rd),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .fw_ready     (fw_ready),
        .req_overflow (req_push && req_full),
        .rep_empty    (rep_empty),
        .rep_head     (rep_head),
        .rep_pop      (rep_pop),
        .irq          (irq)
    );
endmodule

// File: tb/test_cqp_host_port.sv
// Directed bench: one task per scenario. Variant A is instance
// i_cqp_host_port and variant B is i_cqp_host_port_b, both on the same bus.
module test_cqp_host_port;
    import cqp_pkg::*;

    localparam int DEPTH = 8;
    localparam logic [31:0] TBL = 32'h0000_2000;
    localparam logic [31:0] MEM = 32'h0000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata_a, rdata_b;
    logic        req_valid_a, req_valid_b;
    logic [31:0] req_data_a, req_data_b;
    logic        req_pop = 1'b0;
    logic        rsp_push = 1'b0;
    logic [31:0] rsp_data = '0;
    logic        rsp_full_a, rsp_full_b;
    logic        fw_ready = 1'b0;
    logic        irq_a, irq_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    cqp_host_port #(.VARIANT(VAR_A), .REQ_DEPTH(DEPTH), .RSP_DEPTH(DEPTH),
                    .CFG_TBL_LOC(TBL), .CFG_MEM_LOC(MEM)) i_cqp_host_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(rdata_a),
        .req_valid(req_valid_a), .req_data(req_data_a), .req_pop(req_pop),
        .rsp_push(rsp_push), .rsp_data(rsp_data), .rsp_full(rsp_full_a),
        .fw_ready(fw_ready), .irq(irq_a));

    cqp_host_port #(.VARIANT(VAR_B), .REQ_DEPTH(DEPTH), .RSP_DEPTH(DEPTH),
                    .CFG_TBL_LOC(TBL), .CFG_MEM_LOC(MEM)) i_cqp_host_port_b (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(rdata_b),
        .req_valid(req_valid_b), .req_data(req_data_b), .req_pop(req_pop),
        .rsp_push(rsp_push), .rsp_data(rsp_data), .rsp_full(rsp_full_b),
        .fw_ready(fw_ready), .irq(irq_b));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Strobe held for 'hold' edges; data sampled at the following negedge.
    task automatic bus_read(input logic [7:0] a, input int hold);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        repeat (hold) @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic dev_push(input logic [31:0] d);
        @(negedge clk);
        rsp_push = 1'b1; rsp_data = d;
        @(negedge clk);
        rsp_push = 1'b0;
    endtask

    task automatic dev_pop();
        @(negedge clk);
        req_pop = 1'b1;
        @(negedge clk);
        req_pop = 1'b0;
    endtask

    task automatic t_reset();
        check("R7 irq after reset", {31'b0, irq_a}, 32'h0);
        check("R1 req_valid after reset", {31'b0, req_valid_a}, 32'h0);
        bus_read(OFS_MASK, 1);
        check("R6 mask reset A", rdata_a, 32'h08);
        check("R6 mask reset B", rdata_b, 32'h04);
        bus_read(OFS_STATUS, 1);
        check("R2 status clear after reset", rdata_a, 32'h0);
    endtask

    task automatic t_request();
        bus_write(OFS_REQUEST, 32'h1000_0040);
        bus_write(OFS_REQUEST, 32'h1000_0080);
        bus_write(OFS_REQUEST, 32'h1000_00C0);
        check("R1 valid", {31'b0, req_valid_a}, 32'h1);
        check("R1 first", req_data_a, 32'h1000_0040);
        dev_pop();
        check("R1 second", req_data_a, 32'h1000_0080);
        dev_pop();
        check("R1 third", req_data_a, 32'h1000_00C0);
        dev_pop();
        check("R1 drained", {31'b0, req_valid_a}, 32'h0);
    endtask

    task automatic t_overflow();
        for (int i = 0; i <= DEPTH; i++) bus_write(OFS_REQUEST, 32'hA000_0000 + i);
        bus_read(OFS_STATUS, 1);
        check("R2 overflow bit", rdata_a & 32'h1, 32'h1);
        for (int i = 0; i < DEPTH; i++) begin
            check("R2 kept entry", req_data_a, 32'hA000_0000 + i);
            dev_pop();
        end
        check("R2 extra dropped", {31'b0, req_valid_a}, 32'h0);
        bus_read(OFS_STATUS, 1);
        check("R2 overflow sticky", rdata_a & 32'h1, 32'h1);
    endtask

    task automatic t_reply();
        dev_push(32'hC0DE_0001);
        dev_push(32'hC0DE_0002);
        @(negedge clk);
        check("R7 masked irq A", {31'b0, irq_a}, 32'h0);
        bus_read(OFS_STATUS, 1);
        check("R8 pending A", rdata_a & 32'h8, 32'h8);
        check("R8 pending B", rdata_b & 32'h4, 32'h4);
        bus_write(OFS_MASK, 32'h0);
        @(negedge clk);
        check("R7 irq A unmasked", {31'b0, irq_a}, 32'h1);
        check("R7 irq B unmasked", {31'b0, irq_b}, 32'h1);
        bus_read(OFS_MASK, 1);
        check("R6 mask readback", rdata_a, 32'h0);
        bus_read(OFS_REPLY, 3);
        check("R3 R5 first reply", rdata_a, 32'hC0DE_0001);
        bus_read(OFS_REPLY, 1);
        check("R5 second reply kept", rdata_a, 32'hC0DE_0002);
        @(negedge clk);
        check("R7 irq low when empty", {31'b0, irq_a}, 32'h0);
        bus_read(OFS_STATUS, 1);
        check("R8 pending clear", rdata_a & 32'h8, 32'h0);
        dev_push(32'hC0DE_0003);
        bus_write(OFS_MASK, 32'h8);
        @(negedge clk);
        check("R7 variant A masked by bit 3", {31'b0, irq_a}, 32'h0);
        check("R7 variant B ignores bit 3", {31'b0, irq_b}, 32'h1);
        bus_read(OFS_REPLY, 1);
        check("R3 third reply", rdata_a, 32'hC0DE_0003);
    endtask

    task automatic t_empty_read();
        bus_read(OFS_REPLY, 1);
        check("R4 empty sentinel", rdata_a, 32'hFFFF_FFFF);
        bus_read(OFS_REPLY, 2);
        check("R4 empty sentinel held", rdata_a, 32'hFFFF_FFFF);
        check("R4 irq unchanged", {31'b0, irq_a}, 32'h0);
        dev_push(32'h5555_AAAA);
        bus_read(OFS_REPLY, 1);
        check("R4 queue intact after empty read", rdata_a, 32'h5555_AAAA);
    endtask

    task automatic t_scratch_misc();
        bus_read(OFS_SCRATCH, 1);
        check("R9 not ready", rdata_a, 32'h0);
        fw_ready = 1'b1;
        bus_read(OFS_SCRATCH, 1);
        check("R9 ready", rdata_a, 32'hFFFF_0000);
        bus_write(OFS_DOORBELL, 32'h0000_0005);
        bus_read(OFS_DOORBELL, 1);
        check("R10 doorbell", rdata_a, 32'h0000_0005);
        bus_read(OFS_CFG_TBL, 1);
        check("R10 cfg table", rdata_a, TBL);
        bus_read(OFS_CFG_MEM, 1);
        check("R10 cfg mem", rdata_a, MEM);
        bus_read(8'h50, 1);
        check("R10 unmapped", rdata_a, 32'h0);
    endtask

    task automatic t_reply_full();
        for (int i = 0; i <= DEPTH; i++) dev_push(32'hB000_0000 + i);
        check("R11 full flag", {31'b0, rsp_full_a}, 32'h1);
        for (int i = 0; i < DEPTH; i++) begin
            bus_read(OFS_REPLY, 1);
            check("R11 kept reply", rdata_a, 32'hB000_0000 + i);
        end
        check("R11 not full", {31'b0, rsp_full_a}, 32'h0);
        bus_read(OFS_REPLY, 1);
        check("R11 extra dropped", rdata_a, 32'hFFFF_FFFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_request();
        t_overflow();
        t_reply();
        t_empty_read();
        t_scratch_misc();
        t_reply_full();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule